// File: doc/BRIEF.md
# Dual-Port Memory with Collision Arbitration and Mailbox Interrupts

This block is a 2048-word by 9-bit memory with two fully independent access ports, called left and right. Each port has an enable, a write select, an output enable, an address and separate write and read data buses. Either side can read or write any word, and reads return data one clock after the address is presented. Everything is modelled synchronously on one clock. Tri-state data pins are replaced by a data bus plus a "drive" qualifier, and a port that is not driving shows zero on its read bus.

When both enabled ports address the same word in the same cycle, the block picks a winner. The losing port sees its busy flag high, and a write from that port is dropped for that cycle. With `MASTER=1` the block does this arbitration itself and drives the busy flags. With `MASTER=0` it does no arbitration. Each port's busy flag then copies an external busy input, which lets several devices act together as one wider word under one arbitrating master.

The two highest addresses serve as mailboxes. A write by one side to its mailbox word raises an interrupt on the other side, and that interrupt is cleared when the receiving side reads the word.

Top module: `dpram_arb`

## Requirements
- R1: A port with `en=1, wr=1` stores `wdata` at `addr` at the clock edge, unless that port is busy. A port with `en=1, wr=0` reads `addr`, and the stored value appears on `rdata` after that edge.
- R2: `drive` is 1 in a cycle exactly when the same port had `en=1`, `oe=1` and `wr=0` in the previous cycle. While `drive` is 0, `rdata` is zero.
- R3: In master mode, when both ports are enabled on the same address and neither held that address in the previous cycle, the left port wins. `r_busy` is 1, `l_busy` is 0, and a right-port write is dropped.
- R4: In master mode, when a collision occurs and only one port was enabled on that address in the previous cycle, that port wins and the newcomer gets busy. When both ports were already colliding there, the previous winner keeps the address.
- R5: In master mode, the two busy flags are never both 1, and a busy flag is 1 only while both ports are enabled on equal addresses.
- R6: In slave mode, each port's busy output equals its busy input. A write is dropped while the busy input is 1, and reads still return stored data.
- R7: `r_irq` is set by an effective left write to address 0x7FF. It is cleared by a right read of 0x7FF. If both happen in the same cycle, the set wins.
- R8: `l_irq` is set by an effective right write to address 0x7FE and cleared by a left read of 0x7FE. If both happen in the same cycle, the set wins.
- R9: A port with `en=0` writes nothing, clears no interrupt and drives no data.
- R10: Accesses by the two ports to different addresses in the same cycle both complete, and neither port sees busy.
- R11: After reset, both interrupts, both busy flags (master mode) and both drive flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left write select (1 write, 0 read) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | 11 | Left address |
| l_wdata | input | 9 | Left write data |
| l_rdata | output | 9 | Left read data, zero when not driven |
| l_drive | output | 1 | Left read data is driven |
| l_busy_in | input | 1 | Left busy from an external master (slave mode) |
| l_busy | output | 1 | Left port lost arbitration |
| l_irq | output | 1 | Left mailbox interrupt |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right write select (1 write, 0 read) |
| r_oe | input | 1 | Right output enable |
| r_addr | input | 11 | Right address |
| r_wdata | input | 9 | Right write data |
| r_rdata | output | 9 | Right read data, zero when not driven |
| r_drive | output | 1 | Right read data is driven |
| r_busy_in | input | 1 | Right busy from an external master (slave mode) |
| r_busy | output | 1 | Right port lost arbitration |
| r_irq | output | 1 | Right mailbox interrupt |

## Verification
Random traffic draws addresses from a handful of words, including both mailboxes, so the same-cycle double writes, write-versus-read on one word, continuing collisions and disjoint parallel accesses all recur. A reference array and a reference arbiter separate tie-breaking errors from errors in holding priority. Directed sequences pin down the first-cycle tie, a newcomer losing to an established reader, and mailbox set and clear. A second instance in slave mode shows that writes are gated by the external busy input and that reads of the guarded word still work.

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int AW = 11,
  parameter int DW = 9,
  parameter bit MASTER = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_en,
  input  logic          l_wr,
  input  logic          l_oe,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_drive,
  input  logic          l_busy_in,
  output logic          l_busy,
  output logic          l_irq,
  input  logic          r_en,
  input  logic          r_wr,
  input  logic          r_oe,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_drive,
  input  logic          r_busy_in,
  output logic          r_busy,
  output logic          r_irq
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] BOX_R = {AW{1'b1}};
  localparam logic [AW-1:0] BOX_L = BOX_R - 1'b1;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] l_q, r_q;
  logic [AW-1:0] l_prev_addr, r_prev_addr;
  logic          l_prev_en, r_prev_en, prev_rwin;

  wire clash  = l_en && r_en && (l_addr == r_addr);
  wire l_held = l_prev_en && (l_prev_addr == l_addr);
  wire r_held = r_prev_en && (r_prev_addr == r_addr);
  wire r_wins = clash && r_held && (!l_held || prev_rwin);

  assign l_busy = MASTER ? r_wins : l_busy_in;
  assign r_busy = MASTER ? (clash && !r_wins) : r_busy_in;

  wire l_we = l_en && l_wr && !l_busy;
  wire r_we = r_en && r_wr && !r_busy;
  wire l_rd = l_en && !l_wr;
  wire r_rd = r_en && !r_wr;

  assign l_rdata = l_drive ? l_q : '0;
  assign r_rdata = r_drive ? r_q : '0;

  always_ff @(posedge clk) begin
    if (r_we) mem[r_addr] <= r_wdata;
    if (l_we) mem[l_addr] <= l_wdata;
    l_q <= mem[l_addr];
    r_q <= mem[r_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_drive     <= 1'b0;
      r_drive     <= 1'b0;
      l_irq       <= 1'b0;
      r_irq       <= 1'b0;
      l_prev_en   <= 1'b0;
      r_prev_en   <= 1'b0;
      l_prev_addr <= '0;
      r_prev_addr <= '0;
      prev_rwin   <= 1'b0;
    end else begin
      l_drive     <= l_rd && l_oe;
      r_drive     <= r_rd && r_oe;
      l_prev_en   <= l_en;
      r_prev_en   <= r_en;
      l_prev_addr <= l_addr;
      r_prev_addr <= r_addr;
      prev_rwin   <= r_wins;
      if (l_we && l_addr == BOX_R)      r_irq <= 1'b1;
      else if (r_rd && r_addr == BOX_R) r_irq <= 1'b0;
      if (r_we && r_addr == BOX_L)      l_irq <= 1'b1;
      else if (l_rd && l_addr == BOX_L) l_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int AW = 11,
  parameter bit MASTER = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_en,
  input logic          l_wr,
  input logic          l_oe,
  input logic [AW-1:0] l_addr,
  input logic          l_drive,
  input logic          l_busy_in,
  input logic          l_busy,
  input logic          l_irq,
  input logic          r_en,
  input logic          r_wr,
  input logic          r_oe,
  input logic [AW-1:0] r_addr,
  input logic          r_drive,
  input logic          r_busy_in,
  input logic          r_busy,
  input logic          r_irq
);
  wire same = l_en && r_en && (l_addr == r_addr);

  assert_busy_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    MASTER |-> !(l_busy && r_busy));
  assert_busy_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (MASTER && (l_busy || r_busy)) |-> same);
  assert_clash_loser_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (MASTER && same) |-> (l_busy || r_busy));
  assert_ldrive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    l_drive |-> $past(l_en && l_oe && !l_wr));
  assert_rdrive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    r_drive |-> $past(r_en && r_oe && !r_wr));
  assert_rirq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && l_wr && !l_busy && l_addr == {AW{1'b1}}) |=> r_irq);
  assert_lirq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && r_wr && !r_busy && r_addr == ({AW{1'b1}} - 1'b1)) |=> l_irq);
  assert_slave_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !MASTER |-> (l_busy == l_busy_in && r_busy == r_busy_in));
endmodule

bind dpram_arb dpram_arb_chk #(.AW(AW), .MASTER(MASTER)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_drive(l_drive),
  .l_busy_in(l_busy_in), .l_busy(l_busy), .l_irq(l_irq),
  .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_drive(r_drive),
  .r_busy_in(r_busy_in), .r_busy(r_busy), .r_irq(r_irq)
);

// File: tb/sim_dpram_arb.sv
module sim_dpram_arb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic le, lw, lo, re, rw, ro;
  logic [10:0] la, ra;
  logic [8:0] ld, rd;
  logic [8:0] l_rdata, r_rdata;
  logic l_drive, r_drive, l_busy, r_busy, l_irq, r_irq;

  logic se, sw, sbi;
  logic [10:0] sa;
  logic [8:0] sd;
  logic [8:0] s_ldata, s_rdata;
  logic s_ldrv, s_rdrv, s_lb, s_rb, s_li, s_ri;

  dpram_arb #(.MASTER(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n),
    .l_en(le), .l_wr(lw), .l_oe(lo), .l_addr(la), .l_wdata(ld), .l_rdata(l_rdata),
    .l_drive(l_drive), .l_busy_in(1'b0), .l_busy(l_busy), .l_irq(l_irq),
    .r_en(re), .r_wr(rw), .r_oe(ro), .r_addr(ra), .r_wdata(rd), .r_rdata(r_rdata),
    .r_drive(r_drive), .r_busy_in(1'b0), .r_busy(r_busy), .r_irq(r_irq));

  dpram_arb #(.MASTER(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n),
    .l_en(se), .l_wr(sw), .l_oe(1'b1), .l_addr(sa), .l_wdata(sd), .l_rdata(s_ldata),
    .l_drive(s_ldrv), .l_busy_in(sbi), .l_busy(s_lb), .l_irq(s_li),
    .r_en(1'b0), .r_wr(1'b0), .r_oe(1'b0), .r_addr(11'd0), .r_wdata(9'd0), .r_rdata(s_rdata),
    .r_drive(s_rdrv), .r_busy_in(1'b0), .r_busy(s_rb), .r_irq(s_ri));

  int n_cmp = 0, n_bad = 0;
  logic [8:0] ref_mem [2048];
  logic ple = 0, pre = 0, prw = 0, m_lirq = 0, m_rirq = 0;
  logic [10:0] pla = 0, pra = 0;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_rwin();
    logic coll, lh, rh;
    coll = le && re && la == ra;
    lh = ple && pla == la;
    rh = pre && pra == ra;
    return coll && rh && (!lh || prw);
  endfunction

  task automatic step();
    logic rwin, coll, lwe, rwe, eld, erd;
    logic [8:0] eldat, erdat;
    #1;
    coll = le && re && la == ra;
    rwin = exp_rwin();
    chk("R5 l_busy", l_busy, rwin);
    chk("R3/R4 r_busy", r_busy, coll && !rwin);
    lwe = le && lw && !rwin;
    rwe = re && rw && !(coll && !rwin);
    eld = le && lo && !lw;
    erd = re && ro && !rw;
    eldat = eld ? ref_mem[la] : 9'd0;
    erdat = erd ? ref_mem[ra] : 9'd0;
    if (rwe) ref_mem[ra] = rd;
    if (lwe) ref_mem[la] = ld;
    if (lwe && la == 11'h7FF) m_rirq = 1;
    else if (re && !rw && ra == 11'h7FF) m_rirq = 0;
    if (rwe && ra == 11'h7FE) m_lirq = 1;
    else if (le && !lw && la == 11'h7FE) m_lirq = 0;
    prw = rwin; ple = le; pre = re; pla = la; pra = ra;
    @(posedge clk); #1;
    chk("R2 l_drive", l_drive, eld);
    chk("R2 r_drive", r_drive, erd);
    chk("R1 l_rdata", l_rdata, eldat);
    chk("R1 r_rdata", r_rdata, erdat);
    chk("R7 r_irq", r_irq, m_rirq);
    chk("R8 l_irq", l_irq, m_lirq);
    @(negedge clk);
  endtask

  task automatic setl(logic e, logic w, logic [10:0] a, logic [8:0] d);
    le = e; lw = w; lo = 1'b1; la = a; ld = d;
  endtask
  task automatic setr(logic e, logic w, logic [10:0] a, logic [8:0] d);
    re = e; rw = w; ro = 1'b1; ra = a; rd = d;
  endtask

  function automatic logic [10:0] pick_addr(int k);
    case (k % 6)
      0: return 11'h000;
      1: return 11'h001;
      2: return 11'h002;
      3: return 11'h7FE;
      4: return 11'h7FF;
      default: return 11'h155;
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 2048; i++) ref_mem[i] = 9'd0;
    setl(0, 0, 0, 0); setr(0, 0, 0, 0);
    se = 0; sw = 0; sa = 0; sd = 0; sbi = 0;
    repeat (3) @(negedge clk);
    chk("R11 l_irq", l_irq, 0); chk("R11 r_irq", r_irq, 0);
    chk("R11 l_drive", l_drive, 0); chk("R11 r_drive", r_drive, 0);
    chk("R11 busy", l_busy | r_busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // clear the words the random phase uses
    for (int k = 0; k < 6; k++) begin
      setl(1, 1, pick_addr(k), 9'd0); setr(0, 0, 0, 0); step();
    end
    setl(0, 0, 0, 0); step();
    // R3: fresh same-address double write, left wins
    setl(1, 1, 11'h001, 9'h0A5); setr(1, 1, 11'h001, 9'h15A); step();
    setl(0, 0, 0, 0); setr(1, 0, 11'h001, 0); step();
    chk("R3 stored left data", ref_mem[1], 9'h0A5);
    // R4: right holds the word, left arrives and loses
    setl(1, 1, 11'h001, 9'h033); step();
    chk("R4 left newcomer busy", ref_mem[1], 9'h0A5);
    step();
    // R10: disjoint parallel writes, then reads
    setl(1, 1, 11'h002, 9'h111); setr(1, 1, 11'h155, 9'h0EE); step();
    setl(1, 0, 11'h155, 0); setr(1, 0, 11'h002, 0); step();
    // R7/R8 mailbox set and clear, with R9 disabled read not clearing
    setl(1, 1, 11'h7FF, 9'h042); setr(1, 1, 11'h7FE, 9'h024); step();
    setl(0, 0, 11'h7FE, 0); setr(0, 0, 11'h7FF, 0); step();
    chk("R9 r_irq held", r_irq, 1);
    setl(1, 0, 11'h7FE, 0); setr(1, 0, 11'h7FF, 0); step();
    // R9: disabled write leaves memory intact
    setl(0, 1, 11'h000, 9'h1FF); setr(0, 0, 0, 0); step();
    setl(1, 0, 11'h000, 0); step();
    // R2: read with output enable low is not driven
    lo = 1'b0; step();
    // random mix (R1-R5, R7, R8, R10)
    for (int i = 0; i < 3000; i++) begin
      setl($urandom % 5 != 0, $urandom % 2 == 0, pick_addr($urandom), 9'($urandom));
      setr($urandom % 5 != 0, $urandom % 2 == 0, pick_addr($urandom), 9'($urandom));
      lo = $urandom % 4 != 0; ro = $urandom % 4 != 0;
      step();
    end
    setl(0, 0, 0, 0); setr(0, 0, 0, 0); step();
    // R6: slave instance
    se = 1; sw = 1; sa = 11'h00A; sd = 9'h005; sbi = 0;
    @(posedge clk); #1;
    se = 1; sw = 1; sd = 9'h1AA; sbi = 1; #1;
    chk("R6 busy mirrors input", s_lb, 1);
    @(posedge clk); #1;
    sw = 0; #1;
    chk("R6 busy mirrors input low", s_rb, 0);
    @(posedge clk); #1;
    chk("R6 write blocked, read works", s_ldata, 9'h005);
    chk("R6 drive", s_ldrv, 1);
    se = 0; sbi = 0;
    @(posedge clk); #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule